// File: doc/BRIEF.md
# Serial LED Chain Controller

The block drives a chain of external serial-in, parallel-out shift registers that light up to 24 LEDs. It needs only three pins: a shift clock, a serial data line and a store strobe. Each update pulse latches a fresh 24-bit LED frame and shifts the enabled part of it out, highest LED first. A store strobe then moves the shifted bits onto the external register outputs.

An update pulse can come from three places. The first is a software trigger bit that clears itself. The second is a one-cycle tick from an external timer. The third is an internal divider running from the system clock. For each LED, an access bit picks its value from one of two CPU data words. A per-LED blink enable makes that LED invert on every update pulse. LEDs 0 and 1 can instead follow two external status inputs.

Software reaches five 32-bit words through a simple valid/write/address port. Read data is combinational. Further per-frame options are the clock launch edge, the shift clock divider, up to three idle lead slots before the first data bit, and the store-line mode.

Top module: `led_chain_ctrl`

## Requirements
- R1: During reset, word 0 reads 0x84000000 (trigger pending, falling-edge launch). Words 1 to 4 read 0, every LED frame bit is 0, and the idle pins are shClk=1, serData=0, storeOut=0.
- R2: Address 0 is the control word 0. Its fields are trigger[31], launch edge[26], status select for LED1[25] and LED0[24], and blink enables[23:0]. Address 1 is the control word 1. Its fields are source[31:30], store mode[28], update divider[27:23], shift divider[21:20], lead slots[19:18] and group enables[2:0]. Address 2 is CPU0 data[23:0], address 3 is CPU1 data[23:0] and address 4 is access[23:0]. Reads return the stored fields with the unused bits at 0, in the same cycle as the address.
- R3: With source 0, writing 1 to bit 31 of word 0 starts one frame. Bit 31 reads 1 for exactly 1+2H(L+N+1) cycles from the cycle after the write and then reads 0. Here H=2^shiftDiv, L is the lead slots and N is the chain length. When N=0, bit 31 reads 1 for one cycle only.
- R4: A trigger write while a frame is pending or running starts no second frame. A trigger write while the source is not 0 is ignored and bit 31 stays 0.
- R5: The chain length N is 8 times the position of the highest set group bit plus 1, giving 8, 16 or 24. Bits N-1 down to 0 are shifted MSB first. Bits of a disabled group below the top group are sent as 0. With no group enabled there are no clock edges and no store.
- R6: An access bit of 1 takes that LED's value from CPU1 data; 0 takes it from CPU0 data.
- R7: A LED whose blink bit is 1 inverts its previous frame value at every update pulse instead of loading data.
- R8: When bit 24 (or bit 25) of word 0 is set, LED0 (or LED1) takes the value of statusIn[0] (or statusIn[1]). This override wins over data and blink.
- R9: With source 1, a one-cycle high on timerTick starts a frame. Ticks that arrive during a frame are ignored.
- R10: With source 2, frames start every (updDiv+1)*UPD_SCALE cycles.
- R11: Each shift clock half-period lasts H=2^shiftDiv cycles. With bit 26=1, data launches on the falling shClk edge, the receiver captures on the rising edge and the idle level is 1. With bit 26=0 the edges and the idle level are the opposite.
- R12: With store mode 0, storeOut is high for one shift period (2H cycles) right after the last bit. With store mode 1, storeOut always equals the inverse of shClk.
- R13: Each lead slot adds 2H cycles before the first bit, with shClk held idle and serData at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access valid |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | 3 | Word index 0 to 4 |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the addressed word |
| timerTick | input | 1 | External timer update pulse |
| statusIn | input | 2 | External status for LEDs 0 and 1 |
| shClk | output | 1 | Shift clock to the LED chain |
| serData | output | 1 | Serial LED data |
| storeOut | output | 1 | Store strobe to the LED chain |

## Verification
Register read-back is due in the same cycle as the address. A write takes effect at the next rising edge. The trigger bit stays set for exactly 1+2H(L+N+1) cycles after the write. The store pulse lasts 2H cycles, and divided-source frames recur every (updDiv+1)*UPD_SCALE cycles. The bench drives inputs and samples on the falling clock edge, so every registered result has settled. It models the external shift register: it shifts serData in on each capture edge of shClk and latches the frame at each store rise. It then compares the captured word, the bit count, the busy-cycle count and the spacing between store pulses with values worked out from the formulas above.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;
  localparam int LED_COUNT   = 24;
  localparam int GROUP_SIZE  = 8;
  localparam int GROUP_COUNT = LED_COUNT / GROUP_SIZE;
  localparam int GRP_W       = $clog2(GROUP_COUNT);
  localparam int IDX_W       = $clog2(LED_COUNT);
  localparam int FPID_W      = 5;
  localparam int FPIS_W      = 2;
  localparam int LEAD_W      = 2;
  localparam int ADDR_W      = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL0  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL1  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA0  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DATA1  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_RIGHTS = 3'd4;

  typedef enum logic [1:0] {
    SRC_SOFT  = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_DIV   = 2'd2,
    SRC_NONE  = 2'd3
  } updSrc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_STORE
  } seqState_e;

  // configuration the datapath hands to the sequencer
  typedef struct packed {
    updSrc_e           updSrc;
    logic [FPID_W-1:0] divSel;
    logic [FPIS_W-1:0] shDiv;
    logic [LEAD_W-1:0] leadSlots;
    logic [IDX_W:0]    numBits;
    logic              softReq;
  } chainCfg_t;

  // strobes the sequencer hands to the datapath
  typedef struct packed {
    logic             start;
    logic             done;
    logic             inShift;
    logic             inStore;
    logic             clkHalf;
    logic [IDX_W-1:0] bitIdx;
  } seqStrobe_t;
endpackage

// File: rtl/led_chain_seq.sv
module led_chain_seq
  import led_chain_pkg::*;
#(
  parameter int UPD_SCALE = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  chainCfg_t  cfg,
  input  logic       timerTick,
  output seqStrobe_t str,
  output logic       swPending
);
  localparam int HCNT_W  = (1 << FPIS_W) - 1;
  localparam int DIV_MAX = (1 << FPID_W) * UPD_SCALE;
  localparam int DCNT_W  = $clog2(DIV_MAX + 1);

  seqState_e         state;
  logic [HCNT_W-1:0] halfCnt;
  logic [HCNT_W-1:0] halfLast;
  logic              half;
  logic [IDX_W-1:0]  bitIdx;
  logic [LEAD_W-1:0] leadCnt;
  logic [DCNT_W-1:0] divCnt;
  logic [DCNT_W-1:0] divLast;
  logic              swPendQ;
  logic              idle;
  logic              divTick;
  logic              srcFire;
  logic              startNow;
  logic              halfEnd;
  logic              slotEnd;
  logic              doneNow;

  assign idle     = (state == ST_IDLE);
  assign halfLast = HCNT_W'((32'd1 << cfg.shDiv) - 32'd1);
  assign divLast  = DCNT_W'((int'(cfg.divSel) + 1) * UPD_SCALE - 1);
  assign divTick  = (cfg.updSrc == SRC_DIV) && (divCnt == divLast);

  always_comb begin
    unique case (cfg.updSrc)
      SRC_SOFT:  srcFire = swPendQ;
      SRC_TIMER: srcFire = timerTick;
      SRC_DIV:   srcFire = divTick;
      default:   srcFire = 1'b0;
    endcase
  end

  assign startNow = idle && srcFire;
  assign halfEnd  = !idle && (halfCnt == halfLast);
  assign slotEnd  = halfEnd && half;
  assign doneNow  = (startNow && (cfg.numBits == '0)) ||
                    ((state == ST_STORE) && slotEnd);

  // update-pulse divider
  always_ff @(posedge clk) begin
    if (!rstN || cfg.updSrc != SRC_DIV) divCnt <= '0;
    else if (divTick)                   divCnt <= '0;
    else                                divCnt <= divCnt + DCNT_W'(1);
  end

  // software trigger: set at reset and on an idle write, cleared at frame end
  always_ff @(posedge clk) begin
    if (!rstN)                               swPendQ <= 1'b1;
    else if (cfg.softReq && idle && !swPendQ) swPendQ <= 1'b1;
    else if (doneNow)                        swPendQ <= 1'b0;
  end

  // frame sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      half    <= 1'b1;
      bitIdx  <= '0;
      leadCnt <= '0;
    end else if (startNow && cfg.numBits != '0) begin
      state   <= (cfg.leadSlots != '0) ? ST_LEAD : ST_SHIFT;
      halfCnt <= '0;
      half    <= 1'b0;
      bitIdx  <= IDX_W'(cfg.numBits - 1'b1);
      leadCnt <= cfg.leadSlots - LEAD_W'(1);
    end else if (!idle) begin
      if (halfEnd) begin
        halfCnt <= '0;
        half    <= ~half;
        if (half) begin
          unique case (state)
            ST_LEAD: begin
              if (leadCnt == '0) state <= ST_SHIFT;
              else               leadCnt <= leadCnt - LEAD_W'(1);
            end
            ST_SHIFT: begin
              if (bitIdx == '0) state <= ST_STORE;
              else              bitIdx <= bitIdx - IDX_W'(1);
            end
            default: begin
              state <= ST_IDLE;
              half  <= 1'b1;
            end
          endcase
        end
      end else begin
        halfCnt <= halfCnt + HCNT_W'(1);
      end
    end
  end

  assign str.start   = startNow;
  assign str.done    = doneNow;
  assign str.inShift = (state == ST_SHIFT);
  assign str.inStore = (state == ST_STORE);
  assign str.clkHalf = half;
  assign str.bitIdx  = bitIdx;
  assign swPending   = swPendQ;

  // R3: the trigger bit only drops in the cycle after a frame completes
  p_trig_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swPending) |-> $past(str.done));

  // R12: the store phase is entered only from the last data bit
  p_store_after_last_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(str.inStore) |-> $past(str.inShift && str.bitIdx == '0));

  // R5: within a frame the bit index only holds or steps down by one
  p_bit_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    (str.inShift && $past(str.inShift)) |->
      (str.bitIdx == $past(str.bitIdx) || str.bitIdx == $past(str.bitIdx) - IDX_W'(1)));
endmodule

// File: rtl/led_chain_dp.sv
module led_chain_dp
  import led_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [1:0]        statusIn,
  input  seqStrobe_t        str,
  input  logic              swPending,
  output chainCfg_t         cfg,
  output logic              shClk,
  output logic              serData,
  output logic              storeOut
);
  logic                   launchFall;
  logic [1:0]             statSel;
  logic [LED_COUNT-1:0]   blinkEn;
  updSrc_e                updSrcQ;
  logic                   storeInv;
  logic [FPID_W-1:0]      divSelQ;
  logic [FPIS_W-1:0]      shDivQ;
  logic [LEAD_W-1:0]      leadQ;
  logic [GROUP_COUNT-1:0] grpEn;
  logic [LED_COUNT-1:0]   data0;
  logic [LED_COUNT-1:0]   data1;
  logic [LED_COUNT-1:0]   rights;
  logic [LED_COUNT-1:0]   frame;
  logic [LED_COUNT-1:0]   frameNext;
  logic [IDX_W:0]         numBits;
  logic                   wrEn;
  logic [GRP_W-1:0]       grpOfBit;
  logic                   clkLvl;
  logic                   unusedBits;

  assign wrEn = regValid && regWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      launchFall <= 1'b1;
      statSel    <= '0;
      blinkEn    <= '0;
      updSrcQ    <= SRC_SOFT;
      storeInv   <= 1'b0;
      divSelQ    <= '0;
      shDivQ     <= '0;
      leadQ      <= '0;
      grpEn      <= '0;
      data0      <= '0;
      data1      <= '0;
      rights     <= '0;
    end else if (wrEn) begin
      unique case (regAddr)
        ADDR_CTRL0: begin
          launchFall <= regWdata[26];
          statSel    <= regWdata[25:24];
          blinkEn    <= regWdata[LED_COUNT-1:0];
        end
        ADDR_CTRL1: begin
          updSrcQ  <= updSrc_e'(regWdata[31:30]);
          storeInv <= regWdata[28];
          divSelQ  <= regWdata[27:23];
          shDivQ   <= regWdata[21:20];
          leadQ    <= regWdata[19:18];
          grpEn    <= regWdata[GROUP_COUNT-1:0];
        end
        ADDR_DATA0:  data0  <= regWdata[LED_COUNT-1:0];
        ADDR_DATA1:  data1  <= regWdata[LED_COUNT-1:0];
        ADDR_RIGHTS: rights <= regWdata[LED_COUNT-1:0];
        default: ;
      endcase
    end
  end

  // chain length follows the highest enabled group
  always_comb begin
    numBits = '0;
    for (int g = 0; g < GROUP_COUNT; g++)
      if (grpEn[g]) numBits = (IDX_W+1)'((g + 1) * GROUP_SIZE);
  end

  // per-LED frame source: status override, then blink, then selected CPU word
  for (genvar i = 0; i < LED_COUNT; i++) begin : g_led
    logic baseVal;
    logic blinkVal;
    assign baseVal  = rights[i] ? data1[i] : data0[i];
    assign blinkVal = blinkEn[i] ? ~frame[i] : baseVal;
    if (i < 2) begin : g_stat
      assign frameNext[i] = statSel[i] ? statusIn[i] : blinkVal;
    end else begin : g_plain
      assign frameNext[i] = blinkVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          frame <= '0;
    else if (str.start) frame <= frameNext;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL0:  regRdata = {swPending, 4'b0, launchFall, statSel, blinkEn};
      ADDR_CTRL1:  regRdata = {updSrcQ, 1'b0, storeInv, divSelQ, 1'b0, shDivQ,
                               leadQ, 15'b0, grpEn};
      ADDR_DATA0:  regRdata = {8'b0, data0};
      ADDR_DATA1:  regRdata = {8'b0, data1};
      ADDR_RIGHTS: regRdata = {8'b0, rights};
      default:     regRdata = '0;
    endcase
  end

  assign cfg.updSrc    = updSrcQ;
  assign cfg.divSel    = divSelQ;
  assign cfg.shDiv     = shDivQ;
  assign cfg.leadSlots = leadQ;
  assign cfg.numBits   = numBits;
  assign cfg.softReq   = wrEn && (regAddr == ADDR_CTRL0) && regWdata[31] &&
                         (updSrcQ == SRC_SOFT);

  // pin drive
  assign grpOfBit = GRP_W'(str.bitIdx / GROUP_SIZE);
  assign clkLvl   = str.inShift ? str.clkHalf : 1'b1;
  assign shClk    = launchFall ? clkLvl : ~clkLvl;
  assign serData  = str.inShift && frame[str.bitIdx] && grpEn[grpOfBit];
  assign storeOut = storeInv ? ~shClk : str.inStore;

  assign unusedBits = ^{regWdata[30:29], regWdata[22], regWdata[17:GROUP_COUNT], str.done};

  // R7: the LED frame moves only on an update pulse
  p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !str.start |=> $stable(frame));

  // R13: no data leaves the block outside the shift phase
  p_ser_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !str.inShift |-> !serData);
endmodule

// File: rtl/led_chain_ctrl.sv
module led_chain_ctrl
  import led_chain_pkg::*;
#(
  parameter int UPD_SCALE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regValid,
  input  logic        regWrite,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        timerTick,
  input  logic [1:0]  statusIn,
  output logic        shClk,
  output logic        serData,
  output logic        storeOut
);
  chainCfg_t  cfg;
  seqStrobe_t str;
  logic       swPending;

  led_chain_seq #(.UPD_SCALE(UPD_SCALE)) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .cfg       (cfg),
    .timerTick (timerTick),
    .str       (str),
    .swPending (swPending)
  );

  led_chain_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regValid  (regValid),
    .regWrite  (regWrite),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .statusIn  (statusIn),
    .str       (str),
    .swPending (swPending),
    .cfg       (cfg),
    .shClk     (shClk),
    .serData   (serData),
    .storeOut  (storeOut)
  );
endmodule

// File: tb/led_chain_ctrl_test.sv
module led_chain_ctrl_test;
  localparam int K = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        timerTick = 1'b0;
  logic [1:0]  statusIn = '0;
  logic        shClk, serData, storeOut;

  always #10 clk = ~clk;

  led_chain_ctrl #(.UPD_SCALE(K)) uut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .timerTick(timerTick), .statusIn(statusIn),
    .shClk(shClk), .serData(serData), .storeOut(storeOut)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // external shift-register model
  bit          tbFall = 1;
  bit          tbInv = 0;
  logic        prevSh = 1'b1, prevSt = 1'b0;
  logic [31:0] capReg = '0, lastWord = '0;
  int          capBits = 0, lastBits = 0, storeCnt = 0, stHigh = 0, invMiss = 0;
  int          cyc = 0, lastStoreCyc = 0, prevStoreCyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (tbFall ? (!prevSh && shClk) : (prevSh && !shClk)) begin
        capReg = {capReg[30:0], serData};
        capBits++;
      end
      if (!tbInv && storeOut) stHigh++;
      if (!tbInv && storeOut && !prevSt) begin
        lastWord = capReg;
        lastBits = capBits;
        capBits = 0;
        storeCnt++;
        prevStoreCyc = lastStoreCyc;
        lastStoreCyc = cyc;
      end
      if (tbInv && storeOut !== ~shClk) invMiss++;
    end
    prevSh = shClk;
    prevSt = storeOut;
  end

  logic [31:0] c0Sh = 32'h0400_0000;

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1; regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 0; regWrite = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] c1(input int src, input int fpid, input bit inv,
                                     input int fpis, input int lead, input int grp);
    return (32'(src) << 30) | (32'(inv) << 28) | (32'(fpid) << 23) |
           (32'(fpis) << 20) | (32'(lead) << 18) | 32'(grp);
  endfunction

  // software-triggered frame; returns busy cycles of bit 31
  task automatic runSoft(output int busy);
    logic [31:0] v;
    capBits = 0;
    stHigh = 0;
    wr(3'd0, c0Sh | 32'h8000_0000);
    busy = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd0, v);
      if (!v[31]) break;
      busy++;
      @(negedge clk);
    end
    waitCyc(2);
  endtask

  function automatic logic [31:0] msk(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); chk(v == 32'h8400_0000, "R1 ctrl0 reset", v, 32'h8400_0000);
    rd(3'd1, v); chk(v == 0, "R1 ctrl1 reset", v, 0);
    rd(3'd4, v); chk(v == 0, "R1 rights reset", v, 0);
    chk({shClk, serData, storeOut} == 3'b100, "R1 idle pins", {shClk, serData, storeOut}, 3'b100);
    @(negedge clk); rstN = 1;
    waitCyc(2);
    rd(3'd0, v); chk(v == 32'h0400_0000, "R3 reset trigger self-clears", v, 32'h0400_0000);
    chk(storeCnt == 0, "R5 no store with groups off", storeCnt, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v, e;
    e = c1(0, 21, 1, 3, 2, 5);
    wr(3'd1, e); rd(3'd1, v); chk(v == e, "R2 ctrl1 readback", v, e);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); chk(v == 32'h00FF_FFFF, "R2 data1 width", v, 32'h00FF_FFFF);
    wr(3'd2, 32'h00C3); rd(3'd2, v); chk(v == 32'h00C3, "R2 data0 readback", v, 32'h00C3);
    wr(3'd3, 0);
    wr(3'd1, c1(0, 0, 0, 0, 0, 1));
  endtask

  task automatic t_basic;
    int b, s0;
    s0 = storeCnt;
    runSoft(b);
    chk(b == 19, "R3 busy cycles N=8 H=1", b, 19);
    chk((lastWord & 32'hFF) == 32'hC3 && lastBits == 8, "R5 word 8 bits", lastWord, 32'hC3);
    chk(stHigh == 2, "R12 store pulse width", stHigh, 2);
    chk(storeCnt == s0 + 1, "R12 one store", storeCnt, s0 + 1);
  endtask

  task automatic t_groups;
    int b;
    wr(3'd2, 32'h12_3456);
    wr(3'd1, c1(0, 0, 0, 0, 0, 4));
    runSoft(b);
    chk(lastBits == 24 && (lastWord & msk(24)) == 32'h12_0000, "R5 top group only",
        lastWord & msk(24), 32'h12_0000);
    wr(3'd1, c1(0, 0, 0, 0, 0, 3));
    runSoft(b);
    chk(lastBits == 16 && (lastWord & msk(16)) == 32'h3456, "R5 two groups",
        lastWord & msk(16), 32'h3456);
  endtask

  task automatic t_rights;
    int b;
    wr(3'd1, c1(0, 0, 0, 0, 0, 1));
    wr(3'd2, 32'hA5); wr(3'd3, 32'h5A); wr(3'd4, 32'h0F);
    runSoft(b);
    chk((lastWord & 32'hFF) == 32'hAA, "R6 per-LED CPU select", lastWord & 32'hFF, 32'hAA);
    wr(3'd4, 0); wr(3'd3, 0);
  endtask

  task automatic t_blink;
    int b;
    wr(3'd2, 32'h20);
    runSoft(b);
    c0Sh = 32'h0400_0008;
    runSoft(b);
    chk((lastWord & 32'hFF) == 32'h28, "R7 blink first pulse", lastWord & 32'hFF, 32'h28);
    runSoft(b);
    chk((lastWord & 32'hFF) == 32'h20, "R7 blink second pulse", lastWord & 32'hFF, 32'h20);
  endtask

  task automatic t_override;
    int b;
    c0Sh = 32'h0700_0001;
    statusIn = 2'b10;
    wr(3'd2, 32'h21);
    runSoft(b);
    chk((lastWord & 32'hFF) == 32'h22, "R8 status override", lastWord & 32'hFF, 32'h22);
    c0Sh = 32'h0400_0000;
    statusIn = 2'b00;
  endtask

  task automatic t_edge;
    int b;
    c0Sh = 32'h0000_0000;
    tbFall = 0;
    wr(3'd0, c0Sh);
    wr(3'd2, 32'h96);
    chk(shClk == 1'b0, "R11 rising-mode idle level", shClk, 0);
    runSoft(b);
    chk((lastWord & 32'hFF) == 32'h96 && lastBits == 8, "R11 rising-edge launch",
        lastWord & 32'hFF, 32'h96);
    c0Sh = 32'h0400_0000;
    wr(3'd0, c0Sh);
    tbFall = 1;
    waitCyc(1);
  endtask

  task automatic t_timing;
    int b;
    wr(3'd1, c1(0, 0, 0, 2, 0, 1));
    runSoft(b);
    chk(b == 73, "R11 shift divider H=4 busy", b, 73);
    chk(stHigh == 8, "R12 store width H=4", stHigh, 8);
    wr(3'd1, c1(0, 0, 0, 0, 3, 1));
    runSoft(b);
    chk(b == 25, "R13 three lead slots", b, 25);
    chk((lastWord & 32'hFF) == 32'h96, "R13 word after lead", lastWord & 32'hFF, 32'h96);
  endtask

  task automatic t_inv;
    int b;
    tbInv = 1; invMiss = 0;
    wr(3'd1, c1(0, 0, 1, 0, 0, 1));
    runSoft(b);
    chk(invMiss == 0, "R12 inverted shift clock store", invMiss, 0);
    chk(capBits == 8, "R12 bits in inverted mode", capBits, 8);
    wr(3'd1, c1(0, 0, 0, 0, 0, 1));
    tbInv = 0;
    waitCyc(1);
  endtask

  task automatic t_ignore;
    logic [31:0] v;
    int s0;
    s0 = storeCnt;
    wr(3'd0, c0Sh | 32'h8000_0000);
    waitCyc(5);
    wr(3'd0, c0Sh | 32'h8000_0000);
    waitCyc(60);
    chk(storeCnt == s0 + 1, "R4 trigger while busy ignored", storeCnt, s0 + 1);
    wr(3'd1, c1(1, 0, 0, 0, 0, 1));
    wr(3'd0, c0Sh | 32'h8000_0000);
    rd(3'd0, v);
    waitCyc(30);
    chk(v[31] == 1'b0 && storeCnt == s0 + 1, "R4 trigger ignored in timer mode", v, 0);
  endtask

  task automatic t_timer;
    int s0;
    wr(3'd2, 32'h5C);
    s0 = storeCnt;
    @(negedge clk); timerTick = 1; @(negedge clk); timerTick = 0;
    waitCyc(30);
    chk(storeCnt == s0 + 1 && (lastWord & 32'hFF) == 32'h5C, "R9 timer tick frame",
        lastWord & 32'hFF, 32'h5C);
    @(negedge clk); timerTick = 1; @(negedge clk); timerTick = 0;
    waitCyc(3);
    @(negedge clk); timerTick = 1; @(negedge clk); timerTick = 0;
    waitCyc(40);
    chk(storeCnt == s0 + 2, "R9 tick during frame ignored", storeCnt, s0 + 2);
  endtask

  task automatic t_div;
    int s0;
    wr(3'd1, c1(2, 15, 0, 0, 0, 1));
    s0 = storeCnt;
    for (int i = 0; i < 2000 && storeCnt < s0 + 2; i++) @(negedge clk);
    chk(lastStoreCyc - prevStoreCyc == 64, "R10 divided period 64",
        lastStoreCyc - prevStoreCyc, 64);
    wr(3'd1, c1(3, 0, 0, 0, 0, 1));
    wr(3'd1, c1(2, 9, 0, 0, 0, 1));
    s0 = storeCnt;
    for (int i = 0; i < 2000 && storeCnt < s0 + 2; i++) @(negedge clk);
    chk(lastStoreCyc - prevStoreCyc == 40, "R10 divided period 40",
        lastStoreCyc - prevStoreCyc, 40);
    wr(3'd1, c1(3, 0, 0, 0, 0, 1));
  endtask

  initial begin
    waitCyc(3);
    t_reset();
    t_regs();
    t_basic();
    t_groups();
    t_rights();
    t_blink();
    c0Sh = 32'h0400_0000;
    t_override();
    t_edge();
    t_timing();
    wr(3'd1, c1(0, 0, 0, 0, 0, 1));
    t_inv();
    t_ignore();
    t_timer();
    t_div();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule